// File: doc/BRIEF.md
# Core-Rail Low-Voltage Suspend Handler

This block compares each new digitized reading of the processor core supply with a programmable low threshold. A reading strictly below the threshold means the rail has dropped, as it does when the platform enters a sleep state. While the rail is low, the block suspends three thermal-management functions:

- it holds the thermal-event timer at its present count, which also stops thermal-event monitoring;
- it freezes the adaptive minimum-temperature loop, so that the minimum-temperature setting cannot move;
- it inhibits entry into the shutdown state.

All three are released automatically once a later reading is at or above the threshold.

The comparison is made only when the conversion strobe is high, so the gating outputs change at most once per conversion. A low reading also sets a sticky status flag, which stays set until a read-to-clear pulse arrives. An alert request is derived from that flag and the alert-enable bit. The converter, the serial management slave and the fan loop sit outside this block and appear here only as ports.

Top module: `core_rail_suspend`

## Requirements
- R1: After reset, every output (status, alert, timer hold, loop freeze, shutdown inhibit) is 0.
- R2: A clock edge with `conv_valid` high and `rail_code < low_limit` (unsigned) sets `rail_low_sts` and asserts all three gating outputs. The outputs are visible after that edge.
- R3: A conversion with `rail_code` equal to `low_limit` counts as not low. It neither sets the status flag nor asserts any gating output.
- R4: `alert_req` is high exactly when `rail_low_sts` is high and `alert_en` is high. It is a level, not a pulse.
- R5: `therm_tmr_hold`, `tmin_freeze` and `shdn_inhibit` always carry the same value: 1 while the last conversion was low.
- R6: A conversion with `rail_code >= low_limit` deasserts all three gating outputs at that edge. `rail_low_sts` keeps its value.
- R7: While `conv_valid` is low, changes on `rail_code` or `low_limit` have no effect on the gating outputs or on the status flag.
- R8: A one-cycle `status_clr` clears `rail_low_sts`, and with it `alert_req`. If a low conversion arrives in the same cycle as the clear, the status flag ends set.
- R9: If the status flag is cleared while the rail is still low, the gating outputs stay asserted, and the next low conversion sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_code | input | DATA_W | Latest core-rail conversion result |
| low_limit | input | DATA_W | Programmed low threshold |
| alert_en | input | 1 | Enables the alert request |
| conv_valid | input | 1 | One-cycle strobe marking a new conversion |
| status_clr | input | 1 | Read-to-clear pulse for the status flag |
| rail_low_sts | output | 1 | Sticky rail-low status flag |
| alert_req | output | 1 | Level-active alert request |
| therm_tmr_hold | output | 1 | Holds the thermal-event timer |
| tmin_freeze | output | 1 | Freezes adaptive minimum-temperature control |
| shdn_inhibit | output | 1 | Blocks entry into shutdown |

## Verification
The bench sweeps every reading against every threshold in a 4-bit configuration, so the equality boundary is covered; a design using a less-or-equal compare would gate the functions at the threshold. It changes the inputs with no strobe, which catches a design that compares continuously rather than per conversion. It also applies a clear in the same cycle as a low conversion, where a design with the wrong priority would lose the event. Finally, it clears the flag while the rail stays low, which exposes a design that ties the gating outputs to the sticky flag rather than to the live comparison.

// File: rtl/rail_sus_pkg.sv
package rail_sus_pkg;
  // Strict unsigned compare: a reading equal to the threshold counts as healthy.
  function automatic logic reading_low(input logic [31:0] code, input logic [31:0] lim);
    return code < lim;
  endfunction

  // Next value of the sticky flag: a new event wins over a clear.
  function automatic logic sticky_next(input logic cur, input logic set_ev, input logic clr);
    return set_ev | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rail_compare.sv
module rail_compare #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rail_code,
  input  logic [DATA_W-1:0] low_limit,
  input  logic              conv_valid,
  output logic              low_evt,
  output logic              ok_evt,
  output logic              rail_low_live
);
  import rail_sus_pkg::*;

  localparam int PadW = 32 - DATA_W;

  logic is_low;

  always_comb begin
    is_low  = reading_low({{PadW{1'b0}}, rail_code}, {{PadW{1'b0}}, low_limit});
    low_evt = conv_valid & is_low;
    ok_evt  = conv_valid & ~is_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rail_low_live <= 1'b0;
    else if (conv_valid) rail_low_live <= is_low;
  end
endmodule

// File: rtl/sticky_status.sv
module sticky_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  input  logic alert_en,
  output logic sts,
  output logic alert
);
  import rail_sus_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= 1'b0;
    else        sts <= sticky_next(sts, set_ev, clr);
  end

  assign alert = sts & alert_en;
endmodule

// File: rtl/core_rail_suspend.sv
module core_rail_suspend #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rail_code,
  input  logic [DATA_W-1:0] low_limit,
  input  logic              alert_en,
  input  logic              conv_valid,
  input  logic              status_clr,
  output logic              rail_low_sts,
  output logic              alert_req,
  output logic              therm_tmr_hold,
  output logic              tmin_freeze,
  output logic              shdn_inhibit
);
  // Named internal events, used by the bound checker.
  logic low_evt;
  logic ok_evt;
  logic rail_low_live;

  rail_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .rail_code    (rail_code),
    .low_limit    (low_limit),
    .conv_valid   (conv_valid),
    .low_evt      (low_evt),
    .ok_evt       (ok_evt),
    .rail_low_live(rail_low_live)
  );

  sticky_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (low_evt),
    .clr     (status_clr),
    .alert_en(alert_en),
    .sts     (rail_low_sts),
    .alert   (alert_req)
  );

  // The gating outputs follow the live comparison, never the sticky flag.
  assign therm_tmr_hold = rail_low_live;
  assign tmin_freeze    = rail_low_live;
  assign shdn_inhibit   = rail_low_live;
endmodule

// File: rtl/core_rail_suspend_chk.sv
module core_rail_suspend_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_valid,
  input logic status_clr,
  input logic alert_en,
  input logic low_evt,
  input logic ok_evt,
  input logic rail_low_sts,
  input logic alert_req,
  input logic therm_tmr_hold,
  input logic tmin_freeze,
  input logic shdn_inhibit
);
  p_set_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |=> (rail_low_sts && therm_tmr_hold));

  p_alert_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alert_req == (rail_low_sts && alert_en));

  p_gates_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_tmr_hold == tmin_freeze) && (tmin_freeze == shdn_inhibit));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_evt |=> !therm_tmr_hold);

  p_hold_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |=> $stable(therm_tmr_hold));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !low_evt) |=> !rail_low_sts);

  p_no_set_without_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_evt && !rail_low_sts) |=> !rail_low_sts);
endmodule

bind core_rail_suspend core_rail_suspend_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_valid    (conv_valid),
  .status_clr    (status_clr),
  .alert_en      (alert_en),
  .low_evt       (low_evt),
  .ok_evt        (ok_evt),
  .rail_low_sts  (rail_low_sts),
  .alert_req     (alert_req),
  .therm_tmr_hold(therm_tmr_hold),
  .tmin_freeze   (tmin_freeze),
  .shdn_inhibit  (shdn_inhibit)
);

// File: tb/sim_core_rail_suspend.sv
`timescale 1ns/1ps
module sim_core_rail_suspend;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] rail_code = '0;
  logic [W-1:0] low_limit = '0;
  logic         alert_en = 1'b0;
  logic         conv_valid = 1'b0;
  logic         status_clr = 1'b0;
  logic         rail_low_sts, alert_req, therm_tmr_hold, tmin_freeze, shdn_inhibit;

  int checks = 0;
  int errors = 0;
  logic m_live = 1'b0;
  logic m_sts  = 1'b0;

  always #4 clk = ~clk;

  core_rail_suspend #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .rail_code(rail_code), .low_limit(low_limit),
    .alert_en(alert_en), .conv_valid(conv_valid), .status_clr(status_clr),
    .rail_low_sts(rail_low_sts), .alert_req(alert_req),
    .therm_tmr_hold(therm_tmr_hold), .tmin_freeze(tmin_freeze),
    .shdn_inhibit(shdn_inhibit)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " sts"},    rail_low_sts,   m_sts);
    chk({req, " alert"},  alert_req,      m_sts & alert_en);
    chk({req, " hold"},   therm_tmr_hold, m_live);
    chk({req, " freeze"}, tmin_freeze,    m_live);
    chk({req, " inhib"},  shdn_inhibit,   m_live);
  endtask

  // Drive one cycle at the negative edge, update the model, then sample at the next negative edge.
  task automatic step(input logic cv, input logic clr, input logic [W-1:0] code,
                      input logic [W-1:0] lim, input string req);
    logic low;
    @(negedge clk);
    conv_valid = cv; status_clr = clr; rail_code = code; low_limit = lim;
    @(negedge clk);
    low = (int'(code) < int'(lim));
    if (cv) begin
      m_sts  = (low) ? 1'b1 : (clr ? 1'b0 : m_sts);
      m_live = low;
    end else if (clr) begin
      m_sts = 1'b0;
    end
    conv_valid = 1'b0; status_clr = 1'b0;
    chk_all(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    // R2/R3/R6: exhaustive sweep of reading against threshold, with a clear between points.
    alert_en = 1'b1;
    for (int l = 0; l < 16; l++) begin
      for (int c = 0; c < 16; c++) begin
        step(1'b1, 1'b0, W'(c), W'(l), (c < l) ? "R2 low" : ((c == l) ? "R3 equal" : "R6 ok"));
        step(1'b0, 1'b1, W'(c), W'(l), "R8 clear");
      end
    end

    // R4: alert follows the enable as a level.
    step(1'b1, 1'b0, 4'd2, 4'd9, "R2 set");
    alert_en = 1'b0; @(negedge clk); chk_all("R4 disabled");
    alert_en = 1'b1; @(negedge clk); chk_all("R4 re-enabled");

    // R7: input changes without the strobe are ignored.
    for (int c = 0; c < 16; c++) step(1'b0, 1'b0, W'(c), 4'd0, "R7 no strobe");
    step(1'b1, 1'b0, 4'd9, 4'd3, "R6 release keeps sts");
    for (int c = 0; c < 16; c++) step(1'b0, 1'b0, W'(c), 4'd15, "R7 no strobe healthy");

    // R8: a clear in the same cycle as a low conversion leaves the flag set.
    step(1'b0, 1'b1, 4'd9, 4'd3, "R8 clear");
    step(1'b1, 1'b1, 4'd1, 4'd5, "R8 set wins");
    chk("R8 set wins explicit", rail_low_sts, 1'b1);

    // R9: clear while still low; the gates stay, and the next low conversion re-sets the flag.
    step(1'b0, 1'b1, 4'd1, 4'd5, "R9 clear while low");
    chk("R9 gate kept", therm_tmr_hold, 1'b1);
    chk("R9 sts cleared", rail_low_sts, 1'b0);
    step(1'b1, 1'b0, 4'd0, 4'd5, "R9 reset flag");
    chk("R9 sts again", rail_low_sts, 1'b1);
    chk("R5 gates agree", tmin_freeze & shdn_inhibit, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule